// File: doc/BRIEF.md
# ULPI link-side bus controller

This block sits on the link side of an 8-bit ULPI connection and manages the single shared data bus between the link and the PHY. The PHY owns the bus whenever it raises the direction input. In that state the block only listens. Bytes that arrive together with the next-byte strobe go out as a receive stream. Bytes that arrive without it are kept as the latest status byte. While the direction input is low, the block drives the bus. It either idles with a zero byte, sends a user transmit stream, or sends a register write.

Transmission is paced entirely by the PHY. A byte stays on the bus until the PHY's next-byte strobe accepts it, and the following byte appears in the next cycle. After the final byte has been accepted, the block raises the stop strobe for exactly one cycle. Any change of direction costs one turnaround cycle, during which the bus is neither driven nor sampled.

If the PHY takes the bus back in the middle of a transmit stream, the block releases the bus at once and reports an abort. A register write that is interrupted in the same way is simply sent again, because its request stays raised until it is acknowledged. A transceiver reset is one such write: data 8'h20 to address 6'h04.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While rst_n is low, bus_oe, phy_stp, tx_ready, tx_abort, reg_ack and rx_valid are 0. At the first rising edge with rst_n low, stat_byte is set to 8'h00.
- R2: bus_oe is 0 in every cycle in which phy_dir is high, and in the first cycle after phy_dir falls. Reset also counts as a phy_dir-high history, so the first cycle after reset is a turnaround cycle. In every other cycle with phy_dir low, bus_oe is 1.
- R3: While the block owns the bus and has nothing to send, including the stop cycle, bus_out is 8'h00.
- R4: A byte offered while the block is idle and owns the bus is accepted: tx_ready is high in that cycle. The byte appears on bus_out from the next cycle and stays there until a cycle with phy_nxt high. In that cycle tx_ready is high again for the following byte, which appears in the next cycle. The bytes reach the PHY in the order they were offered.
- R5: phy_stp is high for exactly one cycle. That cycle directly follows the cycle in which the byte marked tx_last was on the bus with phy_nxt high.
- R6: A register write first puts the command byte {2'b10, reg_addr} on the bus. After phy_nxt accepts it, reg_wdata follows. After phy_nxt accepts the data, phy_stp is pulsed. reg_ack is high during that stop cycle only.
- R7: When reg_req and tx_valid are both high while the block is idle and owns the bus, the register write starts first. tx_ready stays 0 in that cycle.
- R8: If phy_dir rises while a transmit stream is on the bus, bus_oe drops in that same cycle. tx_abort is then high for one cycle, in the next cycle, and no phy_stp is issued for that stream. A register write interrupted the same way produces no reg_ack and is sent again from its command byte.
- R9: A bus_in byte sampled with phy_dir high, not in a turnaround cycle, and with phy_nxt high is presented on rx_data, with rx_valid high, for one cycle in the next cycle.
- R10: A bus_in byte sampled under the same conditions but with phy_nxt low becomes stat_byte from the next cycle. rx_valid stays low for it.
- R11: In the first cycle after phy_dir rises, bus_in is ignored: neither rx_valid nor stat_byte reacts to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock supplied by the PHY |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_dir | input | 1 | Bus ownership from the PHY, high = PHY drives |
| phy_nxt | input | 1 | PHY next-byte strobe |
| phy_stp | output | 1 | One-cycle end-of-stream strobe to the PHY |
| bus_in | input | 8 | Value seen on the shared data bus |
| bus_out | output | 8 | Value the link drives onto the data bus |
| bus_oe | output | 1 | Output enable for bus_out |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_last | input | 1 | Offered byte ends the stream |
| tx_ready | output | 1 | Offered byte is taken in this cycle |
| tx_abort | output | 1 | One-cycle pulse, stream cut off by the PHY |
| reg_req | input | 1 | Register write request, held until reg_ack |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_ack | output | 1 | Register write completed |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a new byte this cycle |
| stat_byte | output | 8 | Latest status byte from the PHY |

## Verification
Ownership, tx_ready and bus_out follow phy_dir and phy_nxt within the same cycle. The stop strobe, reg_ack, tx_abort, rx_valid, rx_data and stat_byte change one edge after the sample that causes them. The bench applies inputs just after each rising edge. At the falling edge it compares every output with a behavioural model that was advanced on that rising edge. Each result is therefore checked in exactly the cycle in which it falls due. Queues of accepted transmit bytes, received bytes and strobe counts are also compared after each scenario.

// File: rtl/ulpi_link_pkg.sv
// Shared types for the ULPI link-side controller.
// Assumes one clock domain (the PHY-supplied interface clock).
package ulpi_link_pkg;

    // Phase of the outgoing side of the link.
    typedef enum logic [2:0] {
        LS_IDLE  = 3'd0,   // owning or waiting, nothing on the bus
        LS_XMIT  = 3'd1,   // user stream byte on the bus
        LS_RCMD  = 3'd2,   // register write command byte on the bus
        LS_RDATA = 3'd3,   // register write data byte on the bus
        LS_STOP  = 3'd4    // one-cycle stop strobe
    } link_state_t;

endpackage

// File: rtl/ulpi_dir_track.sv
// Tracks bus ownership from the PHY direction input.
// Produces the link drive permission and the PHY receive window, both of
// which exclude the turnaround cycle that follows any change of direction.
// Assumes reset behaves like a PHY-owned history, so the first cycle after
// reset is treated as a turnaround.
module ulpi_dir_track (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_dir,
    output logic link_own,
    output logic phy_window
);

    logic dir_q;

    // Remember last cycle's direction to detect turnaround cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b1;
        end else begin
            dir_q <= phy_dir;
        end
    end

    // Link may drive only after two consecutive low direction samples.
    assign link_own   = rst_n && !phy_dir && !dir_q;
    // PHY data is valid only after two consecutive high direction samples.
    assign phy_window = phy_dir && dir_q;

endmodule

// File: rtl/ulpi_rx_capture.sv
// Captures bytes driven by the PHY. With the next-byte strobe high the byte
// is receive data; with it low the byte is kept as the latest status.
// Assumes the window input already excludes turnaround cycles.
module ulpi_rx_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_window,
    input  logic              phy_nxt,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] stat_byte
);

    // Register receive bytes and their one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= phy_window && phy_nxt;
            if (phy_window && phy_nxt) begin
                rx_data <= bus_in;
            end
        end
    end

    // Keep the most recent status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_byte <= '0;
        end else if (phy_window && !phy_nxt) begin
            stat_byte <= bus_in;
        end
    end

endmodule

// File: rtl/ulpi_tx_engine.sv
// Outgoing side of the link: idle bytes, user transmit streams and register
// writes, each paced by the PHY next-byte strobe and closed by a one-cycle
// stop strobe. Loss of ownership mid-stream drops the activity without a
// stop strobe; a stream reports an abort, a register write is retried
// because its request stays raised.
// Assumes DATA_W = ADDR_W + 2 so the command prefix fills the top bits.
module ulpi_tx_engine
    import ulpi_link_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_own,
    input  logic              phy_nxt,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              tx_abort,
    input  logic              reg_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ack,
    output logic [DATA_W-1:0] bus_out,
    output logic              phy_stp
);

    localparam int unsigned PREFIX_W = DATA_W - ADDR_W;
    localparam logic [PREFIX_W-1:0] REGWR_PFX = {1'b1, {(PREFIX_W-1){1'b0}}};

    link_state_t       state, state_nx;
    logic [DATA_W-1:0] hold_q;
    logic              last_q;
    logic [DATA_W-1:0] wdat_q;
    logic              stop_reg_q;
    logic              abort_q;
    logic              load_tx;
    logic              load_reg;
    logic              ready_c;
    logic [DATA_W-1:0] drv_c;

    // Next phase and load strobes from ownership, strobe and user requests.
    always_comb begin
        state_nx = state;
        load_tx  = 1'b0;
        load_reg = 1'b0;
        ready_c  = 1'b0;
        unique case (state)
            LS_IDLE: begin
                if (link_own) begin
                    if (reg_req) begin
                        load_reg = 1'b1;
                        state_nx = LS_RCMD;
                    end else begin
                        ready_c = 1'b1;
                        if (tx_valid) begin
                            load_tx  = 1'b1;
                            state_nx = LS_XMIT;
                        end
                    end
                end
            end
            LS_XMIT: begin
                if (!link_own) begin
                    state_nx = LS_IDLE;
                end else if (phy_nxt) begin
                    if (last_q) begin
                        state_nx = LS_STOP;
                    end else begin
                        ready_c = 1'b1;
                        if (tx_valid) begin
                            load_tx = 1'b1;
                        end else begin
                            state_nx = LS_STOP;
                        end
                    end
                end
            end
            LS_RCMD: begin
                if (!link_own) begin
                    state_nx = LS_IDLE;
                end else if (phy_nxt) begin
                    state_nx = LS_RDATA;
                end
            end
            LS_RDATA: begin
                if (!link_own) begin
                    state_nx = LS_IDLE;
                end else if (phy_nxt) begin
                    state_nx = LS_STOP;
                end
            end
            default: begin
                state_nx = LS_IDLE;
            end
        endcase
    end

    // Phase register, byte holding registers and the abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= LS_IDLE;
            hold_q     <= '0;
            last_q     <= 1'b0;
            wdat_q     <= '0;
            stop_reg_q <= 1'b0;
            abort_q    <= 1'b0;
        end else begin
            state   <= state_nx;
            abort_q <= (state == LS_XMIT) && !link_own;
            if (load_tx) begin
                hold_q <= tx_data;
                last_q <= tx_last;
            end
            if (load_reg) begin
                hold_q <= {REGWR_PFX, reg_addr};
                last_q <= 1'b0;
                wdat_q <= reg_wdata;
            end
            if ((state_nx == LS_STOP) && (state != LS_STOP)) begin
                stop_reg_q <= (state == LS_RDATA);
            end
        end
    end

    // Byte the link would place on the bus in the current phase.
    always_comb begin
        unique case (state)
            LS_XMIT, LS_RCMD: drv_c = hold_q;
            LS_RDATA:         drv_c = wdat_q;
            default:          drv_c = '0;
        endcase
    end

    assign bus_out  = link_own ? drv_c : '0;
    assign phy_stp  = (state == LS_STOP);
    assign reg_ack  = (state == LS_STOP) && stop_reg_q;
    assign tx_ready = ready_c;
    assign tx_abort = abort_q;

endmodule

// File: rtl/ulpi_link_ctrl.sv
// Link-side controller for an 8-bit ULPI bus. Joins the ownership tracker,
// the receive capture and the transmit engine. The shared bus is split into
// bus_in, bus_out and bus_oe; the pad-level tri-state lives outside.
// Assumes all signals are synchronous to the PHY-supplied clock.
module ulpi_link_ctrl #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_dir,
    input  logic              phy_nxt,
    output logic              phy_stp,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              tx_abort,
    input  logic              reg_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] stat_byte
);

    logic link_own;
    logic phy_window;

    // Ownership and turnaround tracking.
    ulpi_dir_track u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .phy_dir    (phy_dir),
        .link_own   (link_own),
        .phy_window (phy_window)
    );

    // Receive data and status capture.
    ulpi_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .phy_window (phy_window),
        .phy_nxt    (phy_nxt),
        .bus_in     (bus_in),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .stat_byte  (stat_byte)
    );

    // Transmit streams and register writes.
    ulpi_tx_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_own  (link_own),
        .phy_nxt   (phy_nxt),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .tx_abort  (tx_abort),
        .reg_req   (reg_req),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .bus_out   (bus_out),
        .phy_stp   (phy_stp)
    );

    assign bus_oe = link_own;

endmodule

// File: rtl/ulpi_link_ctrl_chk.sv
// Protocol checker for ulpi_link_ctrl, attached through bind below.
// Observes ports only.
module ulpi_link_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic phy_dir,
    input logic phy_nxt,
    input logic phy_stp,
    input logic bus_oe,
    input logic tx_ready,
    input logic tx_abort,
    input logic rx_valid
);

    // R2: never drive while the PHY owns the bus
    p_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phy_dir |-> !bus_oe);

    // R2: the cycle after a falling direction is a turnaround
    p_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_dir) |-> !bus_oe);

    // R5: stop strobe lasts one cycle
    p_stp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_stp |=> !phy_stp);

    // R5: stop strobe follows an accepted byte on a driven bus
    p_stp_after_nxt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_stp) |-> ($past(phy_nxt) && $past(bus_oe)));

    // R8: an abort follows a direction rise and carries no stop strobe
    p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> ($past(phy_dir) && !phy_stp));

    // R4: bytes are taken only while the link owns the bus
    p_ready_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> bus_oe);

    // R9: received data comes only from a PHY-owned cycle with the strobe
    p_rx_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(phy_dir) && $past(phy_nxt)));

endmodule

bind ulpi_link_ctrl ulpi_link_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phy_dir  (phy_dir),
    .phy_nxt  (phy_nxt),
    .phy_stp  (phy_stp),
    .bus_oe   (bus_oe),
    .tx_ready (tx_ready),
    .tx_abort (tx_abort),
    .rx_valid (rx_valid)
);

// File: tb/ulpi_link_ctrl_tb.sv
// Self-checking bench: a behavioural reference model is advanced on every
// rising edge and compared with all outputs at every falling edge.
module ulpi_link_ctrl_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n;
    logic       dir_i, nxt_i;
    logic [7:0] busin_i;
    logic [7:0] tx_data_i;
    logic       tx_valid_i, tx_last_i;
    logic       reg_req_i;
    logic [5:0] reg_addr_i;
    logic [7:0] reg_wdata_i;

    logic       phy_stp, bus_oe, tx_ready, tx_abort, reg_ack, rx_valid;
    logic [7:0] bus_out, rx_data, stat_byte;

    ulpi_link_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_dir   (dir_i),
        .phy_nxt   (nxt_i),
        .phy_stp   (phy_stp),
        .bus_in    (busin_i),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .tx_data   (tx_data_i),
        .tx_valid  (tx_valid_i),
        .tx_last   (tx_last_i),
        .tx_ready  (tx_ready),
        .tx_abort  (tx_abort),
        .reg_req   (reg_req_i),
        .reg_addr  (reg_addr_i),
        .reg_wdata (reg_wdata_i),
        .reg_ack   (reg_ack),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .stat_byte (stat_byte)
    );

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;
    bit  cmp_en = 0;
    bit  tx_en = 0;

    logic [7:0] src_q[$];
    logic [7:0] got_q[$];
    logic [7:0] rxs_q[$];
    int stp_cnt, abort_cnt, ack_cnt;

    // Reference model state: 0 idle, 1 stream, 2 command, 3 data, 4 stop.
    int         md = 0;
    logic [7:0] m_cur = 8'h00, m_wd = 8'h00, m_rxd = 8'h00, m_stat = 8'h00;
    bit         m_last = 0, m_prev_dir = 1, m_stop_reg = 0, m_abort = 0, m_rxv = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic bit m_own();
        return rst_n && !dir_i && !m_prev_dir;
    endfunction

    // Behavioural model advanced on each rising edge.
    always @(posedge clk) begin : ref_model
        bit own, win;
        if (!rst_n) begin
            md = 0; m_prev_dir = 1; m_rxv = 0; m_rxd = 8'h00; m_stat = 8'h00;
            m_abort = 0; m_stop_reg = 0; m_cur = 8'h00; m_wd = 8'h00; m_last = 0;
        end else begin
            own = !dir_i && !m_prev_dir;
            win = dir_i && m_prev_dir;
            m_rxv = win && nxt_i;
            if (win && nxt_i) m_rxd = busin_i;
            if (win && !nxt_i) m_stat = busin_i;
            m_abort = (md == 1) && !own;
            case (md)
                0: if (own) begin
                       if (reg_req_i) begin
                           m_cur = {2'b10, reg_addr_i}; m_wd = reg_wdata_i; m_last = 0; md = 2;
                       end else if (tx_valid_i) begin
                           m_cur = tx_data_i; m_last = tx_last_i; void'(src_q.pop_front()); md = 1;
                       end
                   end
                1: if (!own) md = 0;
                   else if (nxt_i) begin
                       if (m_last) begin md = 4; m_stop_reg = 0; end
                       else if (tx_valid_i) begin
                           m_cur = tx_data_i; m_last = tx_last_i; void'(src_q.pop_front());
                       end else begin md = 4; m_stop_reg = 0; end
                   end
                2: if (!own) md = 0; else if (nxt_i) md = 3;
                3: if (!own) md = 0; else if (nxt_i) begin md = 4; m_stop_reg = 1; end
                default: md = 0;
            endcase
            m_prev_dir = dir_i;
        end
    end

    // Compare every output with the model for the current cycle.
    task automatic compare();
        bit exp_oe, exp_rdy;
        logic [7:0] exp_bus;
        exp_oe = m_own();
        chk(bus_oe == exp_oe, "R2", "bus_oe", bus_oe, exp_oe);
        if (exp_oe) begin
            exp_bus = (md == 1 || md == 2) ? m_cur : (md == 3) ? m_wd : 8'h00;
            if (md == 0 || md == 4) chk(bus_out == exp_bus, "R3", "idle bus_out", bus_out, exp_bus);
            else if (md == 1)      chk(bus_out == exp_bus, "R4", "stream bus_out", bus_out, exp_bus);
            else                   chk(bus_out == exp_bus, "R6", "regwr bus_out", bus_out, exp_bus);
        end
        chk(phy_stp == (md == 4), "R5", "phy_stp", phy_stp, md == 4);
        chk(reg_ack == (md == 4 && m_stop_reg), "R6", "reg_ack", reg_ack, md == 4 && m_stop_reg);
        exp_rdy = exp_oe && ((md == 0 && !reg_req_i) || (md == 1 && nxt_i && !m_last));
        chk(tx_ready == exp_rdy, "R4", "tx_ready", tx_ready, exp_rdy);
        chk(tx_abort == m_abort, "R8", "tx_abort", tx_abort, m_abort);
        chk(rx_valid == m_rxv, "R9", "rx_valid", rx_valid, m_rxv);
        if (m_rxv) chk(rx_data == m_rxd, "R9", "rx_data", rx_data, m_rxd);
        chk(stat_byte == m_stat, "R10", "stat_byte", stat_byte, m_stat);
        if (exp_oe && nxt_i && md >= 1 && md <= 3) got_q.push_back(bus_out);
        if (phy_stp) stp_cnt++;
        if (tx_abort) abort_cnt++;
        if (reg_ack) ack_cnt++;
        if (rx_valid) rxs_q.push_back(rx_data);
    endtask

    task automatic drive_tx();
        tx_valid_i = tx_en && (src_q.size() > 0);
        tx_data_i  = (src_q.size() > 0) ? src_q[0] : 8'h00;
        tx_last_i  = (src_q.size() == 1);
    endtask

    // One cycle: check at the falling edge, then new inputs after the rise.
    task automatic step();
        @(negedge clk);
        if (cmp_en) compare();
        @(posedge clk);
        #1;
        drive_tx();
    endtask

    task automatic clear_logs();
        got_q.delete(); rxs_q.delete();
        stp_cnt = 0; abort_cnt = 0; ack_cnt = 0;
    endtask

    task automatic check_got(string req, logic [7:0] exp[$]);
        chk(got_q.size() == exp.size(), req, "byte count", got_q.size(), exp.size());
        for (int k = 0; k < exp.size() && k < got_q.size(); k++)
            chk(got_q[k] == exp[k], req, "byte order", got_q[k], exp[k]);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] exp_q[$];
        logic [7:0] stat_before;
        int ack_prev;
        rst_n = 0; dir_i = 0; nxt_i = 0; busin_i = 8'h00;
        tx_data_i = 8'h00; tx_valid_i = 0; tx_last_i = 0;
        reg_req_i = 0; reg_addr_i = 6'h00; reg_wdata_i = 8'h00;
        clear_logs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state, with phy_dir low to show reset alone blocks driving
        chk(bus_oe == 0,      "R1", "bus_oe",    bus_oe, 0);
        chk(phy_stp == 0,     "R1", "phy_stp",   phy_stp, 0);
        chk(tx_ready == 0,    "R1", "tx_ready",  tx_ready, 0);
        chk(tx_abort == 0,    "R1", "tx_abort",  tx_abort, 0);
        chk(reg_ack == 0,     "R1", "reg_ack",   reg_ack, 0);
        chk(rx_valid == 0,    "R1", "rx_valid",  rx_valid, 0);
        chk(stat_byte == 0,   "R1", "stat_byte", stat_byte, 0);
        @(posedge clk); #1;
        rst_n = 1; cmp_en = 1;
        step(); step(); step();

        // R4/R5: four-byte stream with gaps in the PHY strobe
        clear_logs();
        src_q = '{8'h3C, 8'hA5, 8'h00, 8'hFF};
        exp_q = src_q;
        tx_en = 1; drive_tx();
        for (int i = 0; i < 60; i++) begin
            nxt_i = (md >= 1 && md <= 3) && (i % 3 != 1);
            step();
            if (md == 0 && src_q.size() == 0) break;
        end
        nxt_i = 0; step(); step();
        check_got("R4", exp_q);
        chk(stp_cnt == 1, "R5", "stop strobes", stp_cnt, 1);

        // R6: transceiver reset write, address 04h, data bit 5
        clear_logs();
        reg_req_i = 1; reg_addr_i = 6'h04; reg_wdata_i = 8'h20;
        for (int i = 0; i < 40; i++) begin
            nxt_i = (md >= 2 && md <= 3) && (i % 2 == 1);
            step();
            if (ack_cnt > 0) begin reg_req_i = 0; break; end
        end
        nxt_i = 0; step(); step();
        exp_q = '{8'h84, 8'h20};
        check_got("R6", exp_q);
        chk(ack_cnt == 1, "R6", "ack pulses", ack_cnt, 1);
        chk(stp_cnt == 1, "R5", "stop strobes after write", stp_cnt, 1);

        // R7: register write wins over a pending stream
        clear_logs();
        src_q = '{8'h11, 8'h22};
        reg_req_i = 1; reg_addr_i = 6'h15; reg_wdata_i = 8'h5A;
        drive_tx();
        ack_prev = 0;
        for (int i = 0; i < 60; i++) begin
            nxt_i = (md >= 1 && md <= 3);
            step();
            if (ack_cnt != ack_prev) begin ack_prev = ack_cnt; reg_req_i = 0; end
            if (md == 0 && src_q.size() == 0 && !reg_req_i) break;
        end
        nxt_i = 0; step(); step();
        exp_q = '{8'h95, 8'h5A, 8'h11, 8'h22};
        check_got("R7", exp_q);

        // R8: PHY takes the bus mid-stream; then R11, R9, R10 on receive
        clear_logs();
        src_q = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5};
        drive_tx();
        for (int i = 0; i < 30; i++) begin
            nxt_i = (md == 1);
            step();
            if (got_q.size() == 2) break;
        end
        stat_before = stat_byte;
        dir_i = 1; nxt_i = 1; busin_i = 8'hAA;
        src_q.delete(); tx_en = 0; drive_tx();
        step();
        // R11: the turnaround byte must leave receive and status untouched
        chk(rx_valid == 0, "R11", "rx_valid after turnaround", rx_valid, 0);
        chk(stat_byte == stat_before, "R11", "stat_byte after turnaround", stat_byte, stat_before);
        nxt_i = 0; busin_i = 8'h4C; step();
        nxt_i = 1; busin_i = 8'h11; step();
        busin_i = 8'h22; step();
        busin_i = 8'h33; step();
        nxt_i = 0; busin_i = 8'h4C; step();
        dir_i = 0; busin_i = 8'h00; step(); step(); step();
        chk(abort_cnt == 1, "R8", "abort pulses", abort_cnt, 1);
        chk(stp_cnt == 0, "R8", "stop strobes on abort", stp_cnt, 0);
        exp_q = '{8'hC1, 8'hC2};
        check_got("R8", exp_q);
        chk(rxs_q.size() == 3, "R9", "received count", rxs_q.size(), 3);
        if (rxs_q.size() == 3) begin
            chk(rxs_q[0] == 8'h11, "R9", "rx byte 0", rxs_q[0], 8'h11);
            chk(rxs_q[1] == 8'h22, "R9", "rx byte 1", rxs_q[1], 8'h22);
            chk(rxs_q[2] == 8'h33, "R9", "rx byte 2", rxs_q[2], 8'h33);
        end
        chk(stat_byte == 8'h4C, "R10", "final status", stat_byte, 8'h4C);

        // R8: register write cut off in its command phase is resent
        clear_logs();
        tx_en = 1;
        reg_req_i = 1; reg_addr_i = 6'h2A; reg_wdata_i = 8'h0F;
        for (int i = 0; i < 10; i++) begin
            step();
            if (md == 2) break;
        end
        dir_i = 1; nxt_i = 0; busin_i = 8'h4C;
        step(); step(); step();
        dir_i = 0;
        for (int i = 0; i < 40; i++) begin
            nxt_i = (md >= 2 && md <= 3);
            step();
            if (ack_cnt > 0) begin reg_req_i = 0; break; end
        end
        nxt_i = 0; step(); step();
        exp_q = '{8'hAA, 8'h0F};
        check_got("R8", exp_q);
        chk(ack_cnt == 1, "R8", "ack after retry", ack_cnt, 1);
        chk(abort_cnt == 0, "R8", "no stream abort for write", abort_cnt, 0);

        finish_run();
    end

endmodule